// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This block owns the program counter of a single-issue 32-bit integer core and decides, once per clock, where the next instruction comes from. It takes an instruction that has already been decoded into a class, a three-bit operation code, a destination register index, the two source operand values and a sign-extended immediate. From these it selects the successor address. That address is one of the sequential address, a PC-relative target, a register-relative target, one of three fixed trap vectors, or the saved exception return address.

The return address for traps is kept in a single exception-PC register inside the block. System calls, breakpoints and undefined instructions all load it, and the return instruction reads it back. Jump-and-link instructions also produce a link value, the address of the following instruction, together with a write enable for the register file. All results are registered. On the clock edge that retires an instruction, the PC moves to its successor, and the link and trap outputs describe that instruction during the following cycle.

Top module: `cflow_pc_unit`

## Requirements
- R1: A synchronous active-high reset loads the PC with the parameter RESET_VEC and the exception PC with zero, and clears link_we_o, link_idx_o, link_val_o and trap_o.
- R2: With class 1 (branch), the op selects the condition: 0 equal, 1 not equal, 2 signed less-than, 3 unsigned less-than, 4 signed greater-or-equal, 5 unsigned greater-or-equal. If the condition holds between ra_i and rb_i, the next PC is PC+4+imm_i.
- R3: The next PC is PC+4 in each of these cases: class 0, a branch whose condition fails, branch ops 6 and 7, and class 2 ops 4 to 7. None of these writes a link or raises a trap.
- R4: Class 2 op 0 (jump-and-link) sets the next PC to PC+4+imm_i and reports link value PC+4 for register rt_i.
- R5: Class 3 (register jump) sets the next PC to ra_i plus an operand. The operand is imm_i when use_imm_i is 1 and rb_i otherwise. The instruction reports link value PC+4 for register rt_i.
- R6: Class 2 op 1 (system call) and op 2 (breakpoint) save PC+4 into the exception PC, jump to SYSCALL_VEC or BREAK_VEC respectively, and raise trap_o for one cycle.
- R7: When undef_i is 1, it overrides the class. The exception PC takes PC+4, the next PC is UNDEF_VEC, trap_o rises, and no link is written.
- R8: Class 2 op 3 (trap return) sets the next PC to the exception PC and leaves the exception PC unchanged.
- R9: Every new PC value, whether computed or taken from a vector or the exception PC, has its two low bits forced to zero.
- R10: A link whose destination index is 0 is dropped: link_we_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 2 | Instruction class: 0 other, 1 branch, 2 jump group, 3 register jump |
| op_i | input | 3 | Operation within the class |
| rt_i | input | 5 | Destination register index for the link value |
| ra_i | input | 32 | First source operand |
| rb_i | input | 32 | Second source operand |
| imm_i | input | 32 | Sign-extended immediate |
| use_imm_i | input | 1 | Register jump adds imm_i instead of rb_i |
| undef_i | input | 1 | Instruction is undefined |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | Link write enable for the instruction just retired |
| link_idx_o | output | 5 | Link destination register |
| link_val_o | output | 32 | Link value (return address) |
| trap_o | output | 1 | The instruction just retired entered a trap vector |
| xpc_o | output | 32 | Saved exception PC |

## Verification
The bench sweeps every branch op against operand pairs that sit on the signed/unsigned boundary, such as 0x80000000 against 0x7FFFFFFF and -1 against 1. A comparator that mixed up signedness, or swapped less-than and greater-or-equal, would send the PC to the wrong successor. Targets built from misaligned immediates and register bases check that the two low bits are always cleared. A missing mask would leave an odd PC. The bench also checks that every destination index of a linking jump, including 0, writes the link only when it should. A trap nested inside a trap must return to the latest saved address, and an undefined flag on a linking jump must suppress the link. A design that kept a stale exception PC, or let the class win over the undefined flag, would fail these.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_JUMP   = 2'd2,
    CLS_JREG   = 2'd3
  } cls_e;

  typedef enum logic [2:0] {
    BR_EQ  = 3'd0,
    BR_NE  = 3'd1,
    BR_LT  = 3'd2,
    BR_LTU = 3'd3,
    BR_GE  = 3'd4,
    BR_GEU = 3'd5
  } br_op_e;

  typedef enum logic [2:0] {
    JG_LINK = 3'd0,
    JG_SYS  = 3'd1,
    JG_BRK  = 3'd2,
    JG_RET  = 3'd3
  } jg_op_e;

  // Source of the successor address
  typedef enum logic [2:0] {
    SEL_SEQ  = 3'd0,
    SEL_REL  = 3'd1,
    SEL_REG  = 3'd2,
    SEL_VSYS = 3'd3,
    SEL_VBRK = 3'd4,
    SEL_VUND = 3'd5,
    SEL_XPC  = 3'd6
  } sel_e;

  typedef struct packed {
    sel_e sel;
    logic link;
    logic save;
    logic trap;
  } flow_t;

endpackage

// File: rtl/cfu_branch_cmp.sv
module cfu_branch_cmp #(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         taken
);
  import cfu_pkg::*;

  logic eq, lt_s, lt_u;

  assign eq   = (a == b);
  assign lt_s = ($signed(a) < $signed(b));
  assign lt_u = (a < b);

  always_comb begin
    case (br_op_e'(op))
      BR_EQ:   taken = eq;
      BR_NE:   taken = !eq;
      BR_LT:   taken = lt_s;
      BR_LTU:  taken = lt_u;
      BR_GE:   taken = !lt_s;
      BR_GEU:  taken = !lt_u;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfu_decide.sv
module cfu_decide (
  input  logic [1:0]     cls,
  input  logic [2:0]     op,
  input  logic           undef,
  input  logic           taken,
  output cfu_pkg::flow_t flow
);
  import cfu_pkg::*;

  always_comb begin
    flow.sel  = SEL_SEQ;
    flow.link = 1'b0;
    flow.save = 1'b0;
    flow.trap = 1'b0;
    if (undef) begin
      flow.sel  = SEL_VUND;
      flow.save = 1'b1;
      flow.trap = 1'b1;
    end else begin
      case (cls_e'(cls))
        CLS_BRANCH: flow.sel = taken ? SEL_REL : SEL_SEQ;
        CLS_JUMP: begin
          case (jg_op_e'(op))
            JG_LINK: begin
              flow.sel  = SEL_REL;
              flow.link = 1'b1;
            end
            JG_SYS: begin
              flow.sel  = SEL_VSYS;
              flow.save = 1'b1;
              flow.trap = 1'b1;
            end
            JG_BRK: begin
              flow.sel  = SEL_VBRK;
              flow.save = 1'b1;
              flow.trap = 1'b1;
            end
            JG_RET:  flow.sel = SEL_XPC;
            default: flow.sel = SEL_SEQ;
          endcase
        end
        CLS_JREG: begin
          flow.sel  = SEL_REG;
          flow.link = 1'b1;
        end
        default: flow.sel = SEL_SEQ;
      endcase
    end
  end

endmodule

// File: rtl/cfu_target.sv
module cfu_target #(
  parameter int             W         = 32,
  parameter int             ALIGN     = 2,
  parameter logic [W-1:0]   SYSCALL_VEC = 32'h0000_0100,
  parameter logic [W-1:0]   BREAK_VEC   = 32'h0000_0200,
  parameter logic [W-1:0]   UNDEF_VEC   = 32'h0000_0300
) (
  input  cfu_pkg::sel_e sel,
  input  logic [W-1:0]  pc,
  input  logic [W-1:0]  ra,
  input  logic [W-1:0]  rb,
  input  logic [W-1:0]  imm,
  input  logic          use_imm,
  input  logic [W-1:0]  xpc,
  output logic [W-1:0]  seq,
  output logic [W-1:0]  next_pc
);
  import cfu_pkg::*;

  localparam logic [W-1:0] STEP = W'(4);

  logic [W-1:0] rel, regt, raw;

  assign seq  = pc + STEP;
  assign rel  = seq + imm;
  assign regt = ra + (use_imm ? imm : rb);

  always_comb begin
    case (sel)
      SEL_REL:  raw = rel;
      SEL_REG:  raw = regt;
      SEL_VSYS: raw = SYSCALL_VEC;
      SEL_VBRK: raw = BREAK_VEC;
      SEL_VUND: raw = UNDEF_VEC;
      SEL_XPC:  raw = xpc;
      default:  raw = seq;
    endcase
  end

  generate
    if (ALIGN == 0) begin : g_noalign
      assign next_pc = raw;
    end else begin : g_align
      localparam logic [W-1:0] MASK = ~((W'(1) << ALIGN) - W'(1));
      assign next_pc = raw & MASK;
    end
  endgenerate

endmodule

// File: rtl/cflow_pc_unit.sv
module cflow_pc_unit #(
  parameter int           W           = 32,
  parameter int           RIDX        = 5,
  parameter int           ALIGN       = 2,
  parameter logic [31:0]  RESET_VEC   = 32'h0000_1000,
  parameter logic [31:0]  SYSCALL_VEC = 32'h0000_0100,
  parameter logic [31:0]  BREAK_VEC   = 32'h0000_0200,
  parameter logic [31:0]  UNDEF_VEC   = 32'h0000_0300
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cls_i,
  input  logic [2:0]      op_i,
  input  logic [RIDX-1:0] rt_i,
  input  logic [W-1:0]    ra_i,
  input  logic [W-1:0]    rb_i,
  input  logic [W-1:0]    imm_i,
  input  logic            use_imm_i,
  input  logic            undef_i,
  output logic [W-1:0]    pc_o,
  output logic            link_we_o,
  output logic [RIDX-1:0] link_idx_o,
  output logic [W-1:0]    link_val_o,
  output logic            trap_o,
  output logic [W-1:0]    xpc_o
);
  import cfu_pkg::*;

  localparam logic [W-1:0] RST_MASK = ~((W'(1) << ALIGN) - W'(1));
  localparam logic [W-1:0] PC_INIT  = W'(RESET_VEC) & RST_MASK;

  logic [W-1:0]    pc_q, xpc_q, link_val_q, seq, next_pc;
  logic [RIDX-1:0] link_idx_q;
  logic            link_we_q, trap_q, taken, link_ok;
  flow_t           flow;

  cfu_branch_cmp #(.W(W)) u_cmp (
    .op    (op_i),
    .a     (ra_i),
    .b     (rb_i),
    .taken (taken)
  );

  cfu_decide u_dec (
    .cls   (cls_i),
    .op    (op_i),
    .undef (undef_i),
    .taken (taken),
    .flow  (flow)
  );

  cfu_target #(
    .W           (W),
    .ALIGN       (ALIGN),
    .SYSCALL_VEC (W'(SYSCALL_VEC)),
    .BREAK_VEC   (W'(BREAK_VEC)),
    .UNDEF_VEC   (W'(UNDEF_VEC))
  ) u_tgt (
    .sel     (flow.sel),
    .pc      (pc_q),
    .ra      (ra_i),
    .rb      (rb_i),
    .imm     (imm_i),
    .use_imm (use_imm_i),
    .xpc     (xpc_q),
    .seq     (seq),
    .next_pc (next_pc)
  );

  // link to register 0 is discarded
  assign link_ok = flow.link && (rt_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= PC_INIT;
      xpc_q      <= '0;
      link_we_q  <= 1'b0;
      link_idx_q <= '0;
      link_val_q <= '0;
      trap_q     <= 1'b0;
    end else begin
      pc_q       <= next_pc;
      trap_q     <= flow.trap;
      link_we_q  <= link_ok;
      link_idx_q <= link_ok ? rt_i : '0;
      link_val_q <= link_ok ? seq : '0;
      if (flow.save) xpc_q <= seq;
    end
  end

  assign pc_o       = pc_q;
  assign xpc_o      = xpc_q;
  assign link_we_o  = link_we_q;
  assign link_idx_o = link_idx_q;
  assign link_val_o = link_val_q;
  assign trap_o     = trap_q;

endmodule

// File: rtl/cflow_pc_unit_chk.sv
module cflow_pc_unit_chk #(
  parameter int          W           = 32,
  parameter int          RIDX        = 5,
  parameter int          ALIGN       = 2,
  parameter logic [31:0] SYSCALL_VEC = 32'h0000_0100,
  parameter logic [31:0] BREAK_VEC   = 32'h0000_0200,
  parameter logic [31:0] UNDEF_VEC   = 32'h0000_0300
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      cls_i,
  input logic [2:0]      op_i,
  input logic            undef_i,
  input logic [W-1:0]    pc_o,
  input logic            link_we_o,
  input logic [RIDX-1:0] link_idx_o,
  input logic [W-1:0]    link_val_o,
  input logic            trap_o,
  input logic [W-1:0]    xpc_o
);
  localparam logic [W-1:0] MASK = ~((W'(1) << ALIGN) - W'(1));
  localparam logic [W-1:0] STEP = W'(4);

  // R9
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_o & ~MASK) == '0);

  // R10
  r0_link_chk: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_idx_o != '0));

  // R3
  seq_chk: assert property (@(posedge clk) disable iff (rst)
    (cls_i == 2'd0 && !undef_i) |=> (pc_o == $past(pc_o) + STEP) && !trap_o && !link_we_o);

  // R8
  ret_chk: assert property (@(posedge clk) disable iff (rst)
    (cls_i == 2'd2 && op_i == 3'd3 && !undef_i) |=>
      (pc_o == ($past(xpc_o) & MASK)) && $stable(xpc_o));

  // R7
  undef_chk: assert property (@(posedge clk) disable iff (rst)
    undef_i |=> trap_o && !link_we_o && (pc_o == (W'(UNDEF_VEC) & MASK))
                && (xpc_o == $past(pc_o) + STEP));

  // R6
  trap_save_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (xpc_o == $past(pc_o) + STEP) &&
      (pc_o == (W'(SYSCALL_VEC) & MASK) || pc_o == (W'(BREAK_VEC) & MASK) ||
       pc_o == (W'(UNDEF_VEC) & MASK)));

  // R6
  xpc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_o |-> $stable(xpc_o));

  // R4
  link_val_chk: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_val_o == $past(pc_o) + STEP));

endmodule

bind cflow_pc_unit cflow_pc_unit_chk #(
  .W           (W),
  .RIDX        (RIDX),
  .ALIGN       (ALIGN),
  .SYSCALL_VEC (SYSCALL_VEC),
  .BREAK_VEC   (BREAK_VEC),
  .UNDEF_VEC   (UNDEF_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cls_i      (cls_i),
  .op_i       (op_i),
  .undef_i    (undef_i),
  .pc_o       (pc_o),
  .link_we_o  (link_we_o),
  .link_idx_o (link_idx_o),
  .link_val_o (link_val_o),
  .trap_o     (trap_o),
  .xpc_o      (xpc_o)
);

// File: tb/cflow_pc_unit_bench.sv
`timescale 1ns/1ps
module cflow_pc_unit_bench;
  localparam logic [31:0] RST_V = 32'h0000_1000;
  localparam logic [31:0] SYS_V = 32'h0000_0100;
  localparam logic [31:0] BRK_V = 32'h0000_0200;
  localparam logic [31:0] UND_V = 32'h0000_0300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cls = 2'd0;
  logic [2:0]  op = 3'd0;
  logic [4:0]  rt = 5'd0;
  logic [31:0] ra = '0, rb = '0, imm = '0;
  logic        use_imm = 1'b0, undef = 1'b0;

  logic [31:0] pc_o, link_val_o, xpc_o;
  logic        link_we_o, trap_o;
  logic [4:0]  link_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_pc, m_xpc;

  always #4 clk = ~clk;

  cflow_pc_unit #(
    .RESET_VEC(RST_V), .SYSCALL_VEC(SYS_V), .BREAK_VEC(BRK_V), .UNDEF_VEC(UND_V)
  ) u_cflow_pc_unit (
    .clk(clk), .rst(rst), .cls_i(cls), .op_i(op), .rt_i(rt), .ra_i(ra), .rb_i(rb),
    .imm_i(imm), .use_imm_i(use_imm), .undef_i(undef), .pc_o(pc_o),
    .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o),
    .trap_o(trap_o), .xpc_o(xpc_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cls = 2'd0; undef = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    m_pc = RST_V; m_xpc = '0;
    chk("R1", "pc after reset", pc_o, RST_V);
    chk("R1", "xpc after reset", xpc_o, 32'h0);
    chk("R1", "trap after reset", {31'b0, trap_o}, 32'h0);
    chk("R1", "link_we after reset", {31'b0, link_we_o}, 32'h0);
    chk("R1", "link_val after reset", link_val_o, 32'h0);
  endtask

  task automatic step(input logic [1:0] c, input logic [2:0] o, input logic [4:0] d,
                      input logic [31:0] a, input logic [31:0] b, input logic [31:0] im,
                      input logic ui, input logic ud, input string tag);
    logic [31:0] seq, nxt, nx;
    logic        lw, tr, tk;
    seq = m_pc + 32'd4; nxt = seq; nx = m_xpc; lw = 1'b0; tr = 1'b0; tk = 1'b0;
    if (ud) begin
      nxt = UND_V; tr = 1'b1; nx = seq;
    end else begin
      case (c)
        2'd1: begin
          case (o)
            3'd0: tk = (a == b);
            3'd1: tk = (a != b);
            3'd2: tk = ($signed(a) < $signed(b));
            3'd3: tk = (a < b);
            3'd4: tk = ($signed(a) >= $signed(b));
            3'd5: tk = (a >= b);
            default: tk = 1'b0;
          endcase
          if (tk) nxt = seq + im;
        end
        2'd2: begin
          case (o)
            3'd0: begin nxt = seq + im; lw = (d != 0); end
            3'd1: begin nxt = SYS_V; tr = 1'b1; nx = seq; end
            3'd2: begin nxt = BRK_V; tr = 1'b1; nx = seq; end
            3'd3: nxt = m_xpc;
            default: nxt = seq;
          endcase
        end
        2'd3: begin nxt = a + (ui ? im : b); lw = (d != 0); end
        default: nxt = seq;
      endcase
    end
    nxt = nxt & ~32'd3;
    cls = c; op = o; rt = d; ra = a; rb = b; imm = im; use_imm = ui; undef = ud;
    @(posedge clk);
    #2;
    chk(tag, "pc", pc_o, nxt);
    chk(tag, "trap", {31'b0, trap_o}, {31'b0, tr});
    chk(tag, "xpc", xpc_o, nx);
    chk(tag, "link_we", {31'b0, link_we_o}, {31'b0, lw});
    if (lw) begin
      chk(tag, "link_val", link_val_o, seq);
      chk(tag, "link_idx", {27'b0, link_idx_o}, {27'b0, d});
    end
    m_pc = nxt; m_xpc = nx;
    cls = 2'd0; undef = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog (all R): run did not finish, actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa [7];
    logic [31:0] pb [7];
    logic [31:0] im4 [4];
    pa[0] = 32'd5;          pb[0] = 32'd5;
    pa[1] = 32'd5;          pb[1] = 32'd7;
    pa[2] = 32'd7;          pb[2] = 32'd5;
    pa[3] = 32'hFFFF_FFFF;  pb[3] = 32'd1;
    pa[4] = 32'd1;          pb[4] = 32'hFFFF_FFFF;
    pa[5] = 32'h8000_0000;  pb[5] = 32'h7FFF_FFFF;
    pa[6] = 32'd0;          pb[6] = 32'hFFFF_FFFF;
    im4[0] = 32'd8; im4[1] = 32'hFFFF_FFF4; im4[2] = 32'd6; im4[3] = 32'h100;

    // R1: reset state
    do_reset();

    // R3: plain instructions fall through
    for (int k = 0; k < 20; k++)
      step(2'd0, 3'(k), 5'(k), $urandom, $urandom, $urandom, 1'(k), 1'b0, "R3");

    // R2 / R3 / R9: branch sweep, imm 6 is misaligned
    for (int o = 0; o < 8; o++)
      for (int p = 0; p < 7; p++)
        for (int i = 0; i < 4; i++)
          step(2'd1, 3'(o), 5'd3, pa[p], pb[p], im4[i], 1'b0, 1'b0,
               (o < 6) ? ((i == 2) ? "R2/R9" : "R2") : "R3");

    // R4 / R10: jump-and-link over every destination
    for (int d = 0; d < 32; d++)
      step(2'd2, 3'd0, 5'(d), 32'h0, 32'h0, 32'(d * 8 - 64), 1'b0, 1'b0,
           (d == 0) ? "R10" : "R4");

    // R5 / R9: register jumps, both operand sources, misaligned bases
    for (int k = 0; k < 16; k++)
      step(2'd3, 3'd0, 5'(k), 32'h2000 + 32'(k), 32'(k * 3), -32'(k), 1'(k), 1'b0,
           (k == 0) ? "R5/R10" : "R5/R9");

    // R3: unused jump-group ops
    for (int o = 4; o < 8; o++)
      step(2'd2, 3'(o), 5'd9, 32'h0, 32'h0, 32'h40, 1'b0, 1'b0, "R3");

    // R6 / R8: system call and breakpoint, each returned from
    step(2'd2, 3'd1, 5'd0, 32'h0, 32'h0, 32'd17, 1'b0, 1'b0, "R6");
    step(2'd0, 3'd0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R3");
    step(2'd2, 3'd3, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R8");
    step(2'd2, 3'd2, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R6");
    step(2'd2, 3'd3, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R8");

    // R7: undefined flag wins over a linking jump and a taken branch
    step(2'd2, 3'd0, 5'd5, 32'h0, 32'h0, 32'h80, 1'b0, 1'b1, "R7");
    step(2'd2, 3'd3, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R8");
    step(2'd1, 3'd0, 5'd0, 32'd4, 32'd4, 32'h80, 1'b0, 1'b1, "R7");
    step(2'd3, 3'd0, 5'd7, 32'h5000, 32'h0, 32'h0, 1'b1, 1'b1, "R7");

    // R6 / R7 / R8: nested trap returns to the latest saved address
    step(2'd2, 3'd1, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R6");
    step(2'd0, 3'd0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, "R7");
    step(2'd2, 3'd3, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R8");

    // R1: reset mid-run, then a return must go to address zero
    do_reset();
    step(2'd2, 3'd3, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R1/R8");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule